// File: doc/BRIEF.md
# Clocked Pulse Width Checker

This block watches a single-bit pulse train using nothing but the system clock. It registers the monitored line once per cycle. It counts how many consecutive cycles the line is seen high, and can also count how many cycles it is seen low. It then compares each count with an expected duration taken from a bank of per-pulse settings. A running pulse index picks the entry for each pulse, so every pulse in a repeating train can have its own expected high width and low width. All durations are whole clock-cycle counts, so a comparison never depends on rounding.

Each comparison produces a one-cycle strobe together with several values: the phase that was checked, the pulse index, the measured count, and a mismatch flag. A saturating error counter keeps the number of mismatches seen since reset. The number of pulses in the train is set by an input, and the index wraps after the last pulse.

Top module: `pulse_width_checker`

## Requirements
- R1: `sig_in` is registered on each rising clock edge. A rise is a sample of 1 following a sample of 0. No check of either phase is reported before the first rise after reset.
- R2: A high measurement counts the clock edges at which `sig_in` is sampled 1, starting at the rise. It is reported with `chk_strobe`=1 and `chk_phase`=0 in the cycle after the first edge that samples 0.
- R3: Entry k of `cfg_bank` occupies bits [24k+23:24k]. A high count is compared with bits [11:0] of the entry for the current index. `chk_mismatch` is 1 exactly when they differ (or per R6).
- R4: When `low_check_en` is 1 at the edge that detects a rise, the preceding low phase is reported. This uses `chk_phase`=1, the index of the pulse that owned that low phase, and a comparison with bits [23:12] of its entry. No low check is made for the low time before the first rise, and none while `low_check_en` is 0.
- R5: The index starts at 0 and advances by one after every high check. After the pulse at index `pulse_total`-1 it wraps to 0. A `pulse_total` of 0 or above 32 acts as 32.
- R6: The measured count saturates at 4095. A count of 4095 is always a mismatch, even when the expected field is 4095.
- R7: `err_count` rises by one in the cycle of each mismatch, holds its value otherwise, and stops at all ones.
- R8: Synchronous reset clears the index, counters and previous sample. After reset, `chk_strobe`, `chk_mismatch`, `chk_index`, `chk_count` and `err_count` are 0.
- R9: `chk_strobe` is high for one cycle per check, and `chk_mismatch` is never high without it. A one-cycle high followed by a one-cycle low yields checks in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Monitored pulse line |
| low_check_en | input | 1 | Enables low-phase checks |
| pulse_total | input | 6 | Pulses per train (0 or over 32 means 32) |
| cfg_bank | input | 768 | 32 entries of {low field, high field}, 12 bits each |
| chk_strobe | output | 1 | One-cycle check result valid |
| chk_mismatch | output | 1 | Checked count differed from expectation |
| chk_phase | output | 1 | 0 = high phase checked, 1 = low phase checked |
| chk_index | output | 5 | Pulse index of the checked phase |
| chk_count | output | 12 | Measured count of the checked phase |
| err_count | output | 16 | Saturating mismatch count |

## Verification
Two events can land in the same cycle. One is a high check on the last pulse of the train, which also wraps the index to 0. The other is a mismatch that moves the error counter, possibly into saturation. The bench runs short trains with deliberately wrong widths and a reduced error-counter width, so that a wrap, a mismatch and counter saturation coincide. The scoreboard judges index, count, flag and counter value together on each strobe. Saturation of the measured count at exactly 4095 is run against an expected field of 4095, so the compare and the saturation rule meet on one check.

// File: rtl/pulse_width_checker.sv
module pulse_width_checker #(
  parameter int NUM_PULSES = 32,
  parameter int CNT_W      = 12,
  parameter int ERR_W      = 16,
  localparam int IDX_W     = $clog2(NUM_PULSES),
  localparam int ENT_W     = 2 * CNT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sig_in,
  input  logic                        low_check_en,
  input  logic [IDX_W:0]              pulse_total,
  input  logic [NUM_PULSES*ENT_W-1:0] cfg_bank,
  output logic                        chk_strobe,
  output logic                        chk_mismatch,
  output logic                        chk_phase,
  output logic [IDX_W-1:0]            chk_index,
  output logic [CNT_W-1:0]            chk_count,
  output logic [ERR_W-1:0]            err_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [ENT_W-1:0] entry [NUM_PULSES];

  for (genvar g = 0; g < NUM_PULSES; g++) begin : g_entry
    assign entry[g] = cfg_bank[g*ENT_W +: ENT_W];
  end

  logic             s_q;
  logic             armed;
  logic             low_pend;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] last_idx;

  wire rise = sig_in & ~s_q;
  wire fall = ~sig_in & s_q;
  wire do_hi = fall & armed;
  wire do_lo = rise & low_pend & low_check_en;
  wire do_chk = do_hi | do_lo;

  assign last_idx = (pulse_total == '0 || pulse_total > (IDX_W+1)'(NUM_PULSES))
                    ? IDX_W'(NUM_PULSES - 1) : IDX_W'(pulse_total - 1'b1);

  wire [CNT_W-1:0] exp_hi = entry[idx][CNT_W-1:0];
  wire [CNT_W-1:0] exp_lo = entry[lo_idx][ENT_W-1:CNT_W];
  wire [CNT_W-1:0] expect_cnt = do_lo ? exp_lo : exp_hi;
  wire             bad = (cnt != expect_cnt) || (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q          <= 1'b0;
      armed        <= 1'b0;
      low_pend     <= 1'b0;
      cnt          <= '0;
      idx          <= '0;
      lo_idx       <= '0;
      chk_strobe   <= 1'b0;
      chk_mismatch <= 1'b0;
      chk_phase    <= 1'b0;
      chk_index    <= '0;
      chk_count    <= '0;
      err_count    <= '0;
    end else begin
      s_q <= sig_in;
      if (rise || fall) cnt <= CNT_W'(1);
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (rise) begin
        armed    <= 1'b1;
        low_pend <= 1'b0;
      end
      if (do_hi) begin
        lo_idx   <= idx;
        idx      <= (idx >= last_idx) ? '0 : idx + 1'b1;
        low_pend <= 1'b1;
      end
      chk_strobe   <= do_chk;
      chk_mismatch <= do_chk & bad;
      if (do_chk) begin
        chk_phase <= do_lo;
        chk_index <= do_lo ? lo_idx : idx;
        chk_count <= cnt;
      end
      if (do_chk && bad && err_count != ERR_MAX) err_count <= err_count + 1'b1;
    end
  end

endmodule

// File: rtl/pulse_width_checker_sva.sv
module pulse_width_checker_sva #(
  parameter int CNT_W = 12,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sig_in,
  input logic             low_check_en,
  input logic             chk_strobe,
  input logic             chk_mismatch,
  input logic             chk_phase,
  input logic [CNT_W-1:0] chk_count,
  input logic [ERR_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  assert_mismatch_has_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    chk_mismatch |-> chk_strobe);

  assert_high_check_after_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (chk_strobe && !chk_phase) |-> !$past(sig_in));

  assert_low_check_after_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (chk_strobe && chk_phase) |-> ($past(sig_in) && $past(low_check_en)));

  assert_saturated_count_fails_R6: assert property (@(posedge clk) disable iff (rst)
    (chk_strobe && chk_count == CNT_MAX) |-> chk_mismatch);

  assert_err_increments_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_mismatch && $past(err_count) != ERR_MAX) |-> err_count == ERR_W'($past(err_count) + 1'b1));

  assert_err_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !chk_mismatch |-> $stable(err_count));
endmodule

bind pulse_width_checker pulse_width_checker_sva #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_sva (
  .clk(clk), .rst(rst), .sig_in(sig_in), .low_check_en(low_check_en),
  .chk_strobe(chk_strobe), .chk_mismatch(chk_mismatch), .chk_phase(chk_phase),
  .chk_count(chk_count), .err_count(err_count)
);

// File: tb/test_pulse_width_checker.sv
module test_pulse_width_checker;
  localparam int NP = 32, CW = 12, EW = 3, ENT = 2 * CW;

  logic clk = 1'b0, rst = 1'b1, sig_in = 1'b0, low_en = 1'b0;
  logic [5:0] total = '0;
  logic [ENT-1:0] cfg [NP];
  logic [NP*ENT-1:0] cfg_flat;
  logic strobe, mm, phase;
  logic [4:0] idx;
  logic [CW-1:0] cnt;
  logic [EW-1:0] err;

  for (genvar g = 0; g < NP; g++) begin : g_flat
    assign cfg_flat[g*ENT +: ENT] = cfg[g];
  end

  pulse_width_checker #(.NUM_PULSES(NP), .CNT_W(CW), .ERR_W(EW)) i_pulse_width_checker (
    .clk(clk), .rst(rst), .sig_in(sig_in), .low_check_en(low_en), .pulse_total(total),
    .cfg_bank(cfg_flat), .chk_strobe(strobe), .chk_mismatch(mm), .chk_phase(phase),
    .chk_index(idx), .chk_count(cnt), .err_count(err)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic          ph;
    logic [4:0]    ix;
    logic [CW-1:0] c;
    logic          m;
    logic [EW-1:0] e;
  } item_t;

  item_t q[$];
  string tags[$];
  int checks = 0, errors = 0;
  int m_idx, m_lo_idx, m_lo_len, m_err;
  bit m_low_valid;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int last_of();
    return (total == 0 || total > NP) ? NP - 1 : int'(total) - 1;
  endfunction

  task automatic push(bit ph, int ix, int len, string tag);
    item_t it;
    int cs, ex;
    bit bad;
    cs = (len > 4095) ? 4095 : len;
    ex = ph ? int'(cfg[ix][23:12]) : int'(cfg[ix][11:0]);
    bad = (cs != ex) || (cs == 4095);
    if (bad && m_err < (1 << EW) - 1) m_err++;
    it.ph = ph; it.ix = 5'(ix); it.c = CW'(cs); it.m = bad; it.e = EW'(m_err);
    q.push_back(it);
    tags.push_back(tag);
  endtask

  task automatic pulse(int hi, int lo, string tag);
    @(negedge clk);
    if (m_low_valid && low_en) push(1'b1, m_lo_idx, m_lo_len, tag);
    m_low_valid = 1'b0;
    sig_in = 1'b1;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk);
    push(1'b0, m_idx, hi, tag);
    m_lo_idx = m_idx;
    m_idx = (m_idx >= last_of()) ? 0 : m_idx + 1;
    m_low_valid = 1'b1;
    m_lo_len = lo;
    sig_in = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_idx = 0; m_lo_idx = 0; m_lo_len = 0; m_err = 0; m_low_valid = 1'b0;
    q.delete();
    tags.delete();
  endtask

  task automatic drain(string req);
    repeat (6) @(negedge clk);
    check(q.size() == 0, req, "results still pending", q.size(), 0);
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    check(strobe == 1'b0, "R8", "strobe after reset", int'(strobe), 0);
    check(mm == 1'b0, "R8", "mismatch after reset", int'(mm), 0);
    check(err == '0, "R8", "err_count after reset", int'(err), 0);
    check(idx == '0, "R8", "index after reset", int'(idx), 0);
    check(cnt == '0, "R8", "count after reset", int'(cnt), 0);
  endtask

  always @(negedge clk) begin
    if (!rst && strobe) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 R4", "unexpected strobe, index", int'(idx), -1);
      end else begin
        item_t exp;
        string tg;
        exp = q.pop_front();
        tg = tags.pop_front();
        check(phase == exp.ph, tg, "phase", int'(phase), int'(exp.ph));
        check(idx == exp.ix, tg, "index", int'(idx), int'(exp.ix));
        check(cnt == exp.c, tg, "count", int'(cnt), int'(exp.c));
        check(mm == exp.m, tg, "mismatch", int'(mm), int'(exp.m));
        check(err == exp.e, tg, "err_count R7", int'(err), int'(exp.e));
      end
    end
    if (!rst && mm && !strobe) check(1'b0, "R9", "mismatch without strobe", 1, 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NP; k++) cfg[k] = {12'(2 + k % 3), 12'(3 + k)};
    do_reset();
    check_reset_state();
    repeat (12) @(negedge clk);
    drain("R1 idle before first rise");

    total = 6'd4;
    low_en = 1'b1;
    for (int p = 0; p < 6; p++) pulse(3 + p % 4, 2 + (p % 4) % 3, "R2 R3 R4 R5 matching");
    pulse(9, 7, "R3 mismatch");
    pulse(2, 1, "R3 mismatch short");
    pulse(5, 4, "R7 counter saturation");
    drain("R2 R3");

    low_en = 1'b0;
    pulse(3, 2, "R4 low disabled");
    pulse(6, 3, "R4 low disabled");
    pulse(5, 5, "R4 low disabled");
    drain("R4");

    for (int s = 0; s < 2; s++) begin
      do_reset();
      total = (s == 0) ? 6'd0 : 6'd40;
      low_en = 1'b1;
      for (int p = 0; p < 34; p++) pulse(3 + p % 32, 2 + (p % 32) % 3, "R5 thirty-two entries");
      drain("R5");
    end

    do_reset();
    total = 6'd2;
    low_en = 1'b1;
    cfg[1][11:0] = 12'hFFF;
    pulse(5, 3, "R6 setup");
    pulse(4095, 2, "R6 exact 4095");
    pulse(4200, 1, "R6 beyond 4095");
    pulse(1, 1, "R9 one-cycle");
    pulse(1, 1, "R9 one-cycle");
    pulse(1, 2, "R9 one-cycle");
    drain("R6 R9");

    do_reset();
    check_reset_state();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule